// File: doc/BRIEF.md
# Auxiliary System Control Register Block

This block is a small memory-mapped peripheral for a workstation I/O controller. It holds byte-wide control registers that the host reaches over a simple synchronous bus. The bus has an address, a write strobe, a read strobe and 8-bit data. The block has six storage locations:

- a configuration byte
- two auxiliary bytes
- a diagnostic byte
- a modem-control byte
- a system-control byte

A seventh address, the power-management location, accepts writes without effect and reads as zero.

The second auxiliary byte holds a latched power-fail flag. The flag follows a synchronous power-fail input whenever the configuration enable allows it. A host command bit can clear it. The interrupt output is the pending flag gated by the same enable.

Writing the second auxiliary byte with its low bit set produces a one-cycle shutdown request. Writing the system-control byte with its low bit set leaves a sticky status code and produces a one-cycle system-reset request.

Two resets exist:

- **Soft reset** clears the configuration, both auxiliary and the modem-control bytes. It leaves the diagnostic and system-control bytes untouched.
- **Power-on reset** clears everything.

Top module: `aux_sysctl_regs`

## Requirements
- R1: Registers are selected by address bits [27:16] only. The keys are 0x180 for configuration, 0x190 for aux A, 0x191 for aux B, 0x1A0 for diagnostic, 0x1B0 for modem control, 0x1F0 for system control and 0xA00 for power management. Address bits [15:0] are ignored.
- R2: The configuration, aux A, diagnostic and modem-control registers store all 8 written bits and read them back unchanged.
- R3: In every clock cycle without an aux B write, aux B bit 2 (pending) is loaded with the power-fail input ANDed with configuration bit 3 (enable).
- R4: irq_out is high exactly when aux B bit 2 and configuration bit 3 are both 1. It is combinational from the registered values.
- R5: An aux B write does the following:
  - bit 0 takes data bit 0;
  - bit 2 keeps its value if data bit 1 is 0 and is cleared if data bit 1 is 1;
  - bit 1 and bits [7:3] always read 0.
- R6: An aux B write with data bit 0 set makes shutdown_req high for exactly the one cycle after the write. No other write raises it.
- R7: A system-control write with data bit 0 set loads the register with 0x02 and makes sysreset_req high for the one cycle after the write. A system-control write with data bit 0 clear leaves the register unchanged and raises no request.
- R8: Soft reset (rst_n low) clears configuration, aux A, aux B and modem control. It preserves the diagnostic and system-control registers.
- R9: Power-on reset (por_n low) clears every register, including diagnostic and system control.
- R10: Reads of the power-management key or of any undecoded key return 0. Writes there change no register.
- R11: bus_rdata is 0 whenever bus_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Soft reset, asynchronous assert, active low |
| por_n | input | 1 | Power-on reset, asynchronous assert, active low |
| bus_addr | input | 28 | Byte address from host |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational while bus_rd is high |
| pwr_fail | input | 1 | Power-fail indication, synchronous to clk |
| irq_out | output | 1 | Level interrupt for a pending, enabled power fail |
| shutdown_req | output | 1 | One-cycle shutdown request |
| sysreset_req | output | 1 | One-cycle system-reset request |

## Verification
The assertions assume the following about the block's inputs:

- Both resets are released in step with the clock.
- pwr_fail, the strobes, the address and the write data change only away from the rising edge.
- Each write strobe stands for exactly one write per high cycle.
- The strobes are never X once reset is released.

The pending-flag and pulse properties compare against the previous cycle's inputs, so they rely on the strobes being low during reset. The bench keeps within these assumptions:

- It drives every input on the falling edge.
- It holds the strobes low while either reset is asserted.
- It releases resets on a falling edge.
- It samples outputs on the falling edge, half a cycle after the registers move.

// File: rtl/aux_ctl_pkg.sv
package aux_ctl_pkg;

  // Address key field: the select is taken from the upper address bits
  localparam int KEY_LSB = 16;
  localparam int KEY_W   = 12;

  // Select vector indices
  localparam int SEL_CFG  = 0;
  localparam int SEL_AUXA = 1;
  localparam int SEL_AUXB = 2;
  localparam int SEL_DIAG = 3;
  localparam int SEL_MCTL = 4;
  localparam int SEL_SYSC = 5;
  localparam int SEL_PWRM = 6;
  localparam int NSEL     = 7;

  // Plain byte registers (store and read back all bits)
  localparam int NPLAIN = 4;

  // Bit positions with behaviour attached
  localparam int PF_EN_BIT   = 3;  // configuration: power-fail enable
  localparam int PF_PEND_BIT = 2;  // aux B: power-fail pending
  localparam int AUXB_CLR_BIT = 1; // aux B write: clear pending
  localparam int AUXB_OFF_BIT = 0; // aux B write: shutdown command
  localparam int SYSC_GO_BIT  = 0; // system control: reset command
  localparam logic [7:0] SYSC_CODE = 8'h02;

  function automatic logic [KEY_W-1:0] key_of(input int idx);
    case (idx)
      SEL_CFG:  key_of = 12'h180;
      SEL_AUXA: key_of = 12'h190;
      SEL_AUXB: key_of = 12'h191;
      SEL_DIAG: key_of = 12'h1A0;
      SEL_MCTL: key_of = 12'h1B0;
      SEL_SYSC: key_of = 12'h1F0;
      default:  key_of = 12'hA00;
    endcase
  endfunction

  // Map plain register slot to its select index
  function automatic int plain_sel(input int slot);
    case (slot)
      0:       plain_sel = SEL_CFG;
      1:       plain_sel = SEL_AUXA;
      2:       plain_sel = SEL_DIAG;
      default: plain_sel = SEL_MCTL;
    endcase
  endfunction

  // Plain register slots that survive the soft reset
  function automatic bit plain_keep(input int slot);
    plain_keep = (slot == 2);
  endfunction

endpackage

// File: rtl/aux_ctl_decode.sv
module aux_ctl_decode
  import aux_ctl_pkg::*;
#(
  parameter int ADDR_W = 28
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NSEL-1:0]   sel
);

  localparam int KW = ADDR_W - KEY_LSB;

  logic [KW-1:0] key;
  logic          addr_low_unused;

  assign key             = addr[ADDR_W-1:KEY_LSB];
  assign addr_low_unused = ^addr[KEY_LSB-1:0];

  for (genvar i = 0; i < NSEL; i++) begin : g_key
    assign sel[i] = (key == KW'(key_of(i)));
  end

  // R1: at most one location selected
  always_comb begin
    a_r1_onehot_select: assert ($onehot0(sel));
  end

endmodule

// File: rtl/aux_ctl_byte_reg.sv
module aux_ctl_byte_reg #(
  parameter int DATA_W       = 8,
  parameter bit KEEP_ON_SOFT = 1'b0
) (
  input  logic              clk,
  input  logic              soft_rst_n,
  input  logic              por_n,
  input  logic              wen,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);

  logic [DATA_W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (wen) q_nxt = wdata;
  end

  if (KEEP_ON_SOFT) begin : g_por_only
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) q <= '0;
      else        q <= q_nxt;
    end
  end else begin : g_soft
    always_ff @(posedge clk or negedge soft_rst_n) begin
      if (!soft_rst_n) q <= '0;
      else             q <= q_nxt;
    end
  end

endmodule

// File: rtl/aux_ctl_pfail.sv
module aux_ctl_pfail
  import aux_ctl_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_auxb,
  input  logic              wr_clr,
  input  logic              wr_off,
  input  logic              pf_en,
  input  logic              pwr_fail,
  output logic [DATA_W-1:0] auxb_q,
  output logic              irq_o,
  output logic              shutdown_o
);

  logic pend_q, pend_nxt;
  logic off_q,  off_nxt;
  logic shut_q, shut_nxt;

  always_comb begin
    off_nxt  = off_q;
    pend_nxt = pwr_fail & pf_en;
    if (wr_auxb) begin
      off_nxt  = wr_off;
      pend_nxt = wr_clr ? 1'b0 : pend_q;
    end
    shut_nxt = wr_auxb & wr_off;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      off_q  <= 1'b0;
      shut_q <= 1'b0;
    end else begin
      pend_q <= pend_nxt;
      off_q  <= off_nxt;
      shut_q <= shut_nxt;
    end
  end

  always_comb begin
    auxb_q               = '0;
    auxb_q[PF_PEND_BIT]  = pend_q;
    auxb_q[AUXB_OFF_BIT] = off_q;
  end

  assign irq_o      = pend_q & pf_en;
  assign shutdown_o = shut_q;

  // R3: pending follows the gated input when no write intervenes
  a_r3_pending_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_auxb) |-> auxb_q[PF_PEND_BIT] == $past(pwr_fail & pf_en));

  // R5: command bit clears pending
  a_r5_cmd_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_auxb & wr_clr) |-> !auxb_q[PF_PEND_BIT]);

  // R5: low bit takes written value
  a_r5_off_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_auxb) |-> auxb_q[AUXB_OFF_BIT] == $past(wr_off));

  // R6: shutdown pulse only after a qualifying write
  a_r6_shutdown_cause: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_o |-> $past(wr_auxb & wr_off));

  a_r6_shutdown_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_auxb & wr_off) |-> shutdown_o);

endmodule

// File: rtl/aux_ctl_sysrst.sv
module aux_ctl_sysrst
  import aux_ctl_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic              wr_sysc,
  input  logic              wr_go,
  output logic [DATA_W-1:0] sysc_q,
  output logic              reset_req_o
);

  logic [DATA_W-1:0] code_q, code_nxt;
  logic              req_q, req_nxt;

  always_comb begin
    code_nxt = code_q;
    if (wr_sysc && wr_go) code_nxt = DATA_W'(SYSC_CODE);
    req_nxt = wr_sysc & wr_go;
  end

  // Status code survives the soft reset
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) code_q <= '0;
    else        code_q <= code_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_nxt;
  end

  assign sysc_q      = code_q;
  assign reset_req_o = req_q;

  // R7: a request always leaves the status code behind
  a_r7_code_with_request: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req_o |-> sysc_q == DATA_W'(SYSC_CODE));

  // R7: writes without the command bit leave the register alone
  a_r7_plain_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_sysc && !wr_go) |-> $stable(sysc_q) && !reset_req_o);

endmodule

// File: rtl/aux_sysctl_regs.sv
module aux_sysctl_regs
  import aux_ctl_pkg::*;
#(
  parameter int ADDR_W = 28,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              pwr_fail,
  output logic              irq_out,
  output logic              shutdown_req,
  output logic              sysreset_req
);

  logic              soft_rst_n;
  logic [NSEL-1:0]   sel;
  logic [DATA_W-1:0] plain_q [NPLAIN];
  logic [DATA_W-1:0] auxb_q;
  logic [DATA_W-1:0] sysc_q;
  logic [DATA_W-1:0] cfg_q;

  // Power-on reset also acts as soft reset
  assign soft_rst_n = rst_n & por_n;

  aux_ctl_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr (bus_addr),
    .sel  (sel)
  );

  for (genvar g = 0; g < NPLAIN; g++) begin : g_plain
    aux_ctl_byte_reg #(
      .DATA_W       (DATA_W),
      .KEEP_ON_SOFT (plain_keep(g))
    ) u_reg (
      .clk        (clk),
      .soft_rst_n (soft_rst_n),
      .por_n      (por_n),
      .wen        (bus_wr & sel[plain_sel(g)]),
      .wdata      (bus_wdata),
      .q          (plain_q[g])
    );
  end

  assign cfg_q = plain_q[0];

  aux_ctl_pfail #(.DATA_W(DATA_W)) u_pfail (
    .clk        (clk),
    .rst_n      (soft_rst_n),
    .wr_auxb    (bus_wr & sel[SEL_AUXB]),
    .wr_clr     (bus_wdata[AUXB_CLR_BIT]),
    .wr_off     (bus_wdata[AUXB_OFF_BIT]),
    .pf_en      (cfg_q[PF_EN_BIT]),
    .pwr_fail   (pwr_fail),
    .auxb_q     (auxb_q),
    .irq_o      (irq_out),
    .shutdown_o (shutdown_req)
  );

  aux_ctl_sysrst #(.DATA_W(DATA_W)) u_sysrst (
    .clk         (clk),
    .rst_n       (soft_rst_n),
    .por_n       (por_n),
    .wr_sysc     (bus_wr & sel[SEL_SYSC]),
    .wr_go       (bus_wdata[SYSC_GO_BIT]),
    .sysc_q      (sysc_q),
    .reset_req_o (sysreset_req)
  );

  // Read mux: selects are one-hot, unmatched keys read zero
  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      for (int i = 0; i < NPLAIN; i++) begin
        if (sel[plain_sel(i)]) bus_rdata = bus_rdata | plain_q[i];
      end
      if (sel[SEL_AUXB]) bus_rdata = bus_rdata | auxb_q;
      if (sel[SEL_SYSC]) bus_rdata = bus_rdata | sysc_q;
    end
  end

  // R4: interrupt never without the enable
  a_r4_irq_needs_enable: assert property (@(posedge clk) disable iff (!soft_rst_n)
    irq_out |-> cfg_q[PF_EN_BIT]);

  // R10: power-management writes touch no stored byte
  a_r10_pwrm_no_store: assert property (@(posedge clk) disable iff (!soft_rst_n)
    $past(bus_wr && sel[SEL_PWRM]) |-> $stable(cfg_q) && $stable(sysc_q)
      && $stable(plain_q[1]) && $stable(plain_q[2]) && $stable(plain_q[3]));

endmodule

// File: tb/tb_aux_sysctl_regs.sv
module tb_aux_sysctl_regs;

  localparam logic [27:0] A_CFG  = 28'h180_0000;
  localparam logic [27:0] A_AUXA = 28'h190_0000;
  localparam logic [27:0] A_AUXB = 28'h191_0000;
  localparam logic [27:0] A_DIAG = 28'h1A0_0000;
  localparam logic [27:0] A_MCTL = 28'h1B0_0000;
  localparam logic [27:0] A_SYSC = 28'h1F0_0000;
  localparam logic [27:0] A_PWRM = 28'hA00_0000;

  logic        clk = 1'b0;
  logic        rst_n, por_n, bus_wr, bus_rd, pwr_fail;
  logic [27:0] bus_addr;
  logic [7:0]  bus_wdata, bus_rdata;
  logic        irq_out, shutdown_req, sysreset_req;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  finished = 1'b0;

  always #5 clk = ~clk;

  aux_sysctl_regs dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .por_n        (por_n),
    .bus_addr     (bus_addr),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .pwr_fail     (pwr_fail),
    .irq_out      (irq_out),
    .shutdown_req (shutdown_req),
    .sysreset_req (sysreset_req)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [27:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [27:0] a, input logic [7:0] exp);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    chk(req, bus_rdata, exp);
    bus_rd = 1'b0;
  endtask

  task automatic t_reset_state;
    rd_chk("R9 cfg after por",  A_CFG,  8'h00);
    rd_chk("R9 auxa after por", A_AUXA, 8'h00);
    rd_chk("R9 auxb after por", A_AUXB, 8'h00);
    rd_chk("R9 diag after por", A_DIAG, 8'h00);
    rd_chk("R9 mctl after por", A_MCTL, 8'h00);
    rd_chk("R9 sysc after por", A_SYSC, 8'h00);
    chk("R4 irq after por", {7'd0, irq_out}, 8'h00);
    chk("R6 shutdown idle", {7'd0, shutdown_req}, 8'h00);
    chk("R7 sysreset idle", {7'd0, sysreset_req}, 8'h00);
  endtask

  task automatic t_plain_regs;
    wr(A_CFG,  8'hA5);
    wr(A_AUXA, 8'h3C);
    wr(A_DIAG, 8'h81);
    wr(A_MCTL, 8'hFF);
    rd_chk("R2 cfg",  A_CFG,  8'hA5);
    rd_chk("R2 auxa", A_AUXA, 8'h3C);
    rd_chk("R2 diag", A_DIAG, 8'h81);
    rd_chk("R2 mctl", A_MCTL, 8'hFF);
    rd_chk("R1 low bits ignored", A_CFG | 28'h000_ABCD, 8'hA5);
    wr(A_MCTL | 28'h000_FFFF, 8'h5A);
    rd_chk("R1 write with low bits", A_MCTL, 8'h5A);
    @(negedge clk);
    bus_addr = A_DIAG; bus_rd = 1'b0;
    #1;
    chk("R11 rdata idle", bus_rdata, 8'h00);
    wr(A_CFG, 8'h00);
  endtask

  task automatic t_undecoded;
    wr(A_PWRM, 8'h77);
    wr(28'h170_0000, 8'h66);
    wr(28'h192_0000, 8'h55);
    rd_chk("R10 pwrm reads 0", A_PWRM, 8'h00);
    rd_chk("R10 undecoded reads 0", 28'h192_0000, 8'h00);
    rd_chk("R10 cfg untouched",  A_CFG,  8'h00);
    rd_chk("R10 auxa untouched", A_AUXA, 8'h3C);
    rd_chk("R10 diag untouched", A_DIAG, 8'h81);
    rd_chk("R10 mctl untouched", A_MCTL, 8'h5A);
    rd_chk("R10 auxb untouched", A_AUXB, 8'h00);
    rd_chk("R10 sysc untouched", A_SYSC, 8'h00);
  endtask

  task automatic t_power_fail;
    pwr_fail = 1'b1;
    repeat (2) @(negedge clk);
    chk("R3 no pending while disabled", {7'd0, irq_out}, 8'h00);
    rd_chk("R3 auxb disabled", A_AUXB, 8'h00);
    wr(A_CFG, 8'h08);
    chk("R3 pending uses old enable", {7'd0, irq_out}, 8'h00);
    @(negedge clk);
    chk("R4 irq raised", {7'd0, irq_out}, 8'h01);
    rd_chk("R3 auxb pending", A_AUXB, 8'h04);
    pwr_fail = 1'b0;
    @(negedge clk);
    chk("R3 pending follows input low", {7'd0, irq_out}, 8'h00);
    pwr_fail = 1'b1;
    @(negedge clk);
    chk("R4 irq again", {7'd0, irq_out}, 8'h01);
    wr(A_AUXB, 8'h02);
    chk("R5 clear command", {7'd0, irq_out}, 8'h00);
    chk("R6 no shutdown on clear", {7'd0, shutdown_req}, 8'h00);
    @(negedge clk);
    chk("R3 re-latched after clear", {7'd0, irq_out}, 8'h01);
    wr(A_AUXB, 8'hFC);
    rd_chk("R5 upper bits dropped, pending kept", A_AUXB, 8'h04);
    wr(A_CFG, 8'h00);
    chk("R4 irq masked by enable", {7'd0, irq_out}, 8'h00);
    pwr_fail = 1'b0;
    @(negedge clk);
    rd_chk("R3 pending cleared when disabled", A_AUXB, 8'h00);
  endtask

  task automatic t_shutdown;
    wr(A_AUXB, 8'h01);
    chk("R6 shutdown pulse", {7'd0, shutdown_req}, 8'h01);
    @(negedge clk);
    chk("R6 shutdown one cycle", {7'd0, shutdown_req}, 8'h00);
    rd_chk("R5 bit0 stored", A_AUXB, 8'h01);
    wr(A_AUXB, 8'h03);
    chk("R6 shutdown with clear", {7'd0, shutdown_req}, 8'h01);
    rd_chk("R5 bit1 never stored", A_AUXB, 8'h01);
    wr(A_AUXB, 8'h00);
    chk("R6 no pulse on bit0 clear", {7'd0, shutdown_req}, 8'h00);
    rd_chk("R5 bit0 cleared", A_AUXB, 8'h00);
  endtask

  task automatic t_sysctl;
    wr(A_SYSC, 8'hFE);
    chk("R7 no request on bit0 clear", {7'd0, sysreset_req}, 8'h00);
    rd_chk("R7 unchanged on bit0 clear", A_SYSC, 8'h00);
    wr(A_SYSC, 8'h01);
    chk("R7 reset request", {7'd0, sysreset_req}, 8'h01);
    @(negedge clk);
    chk("R7 request one cycle", {7'd0, sysreset_req}, 8'h00);
    rd_chk("R7 status code", A_SYSC, 8'h02);
    wr(A_SYSC, 8'h00);
    rd_chk("R7 code sticky", A_SYSC, 8'h02);
  endtask

  task automatic t_soft_reset;
    wr(A_CFG,  8'h77);
    wr(A_AUXA, 8'h11);
    wr(A_AUXB, 8'h01);
    wr(A_DIAG, 8'h42);
    wr(A_MCTL, 8'h99);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    rd_chk("R8 cfg cleared",  A_CFG,  8'h00);
    rd_chk("R8 auxa cleared", A_AUXA, 8'h00);
    rd_chk("R8 auxb cleared", A_AUXB, 8'h00);
    rd_chk("R8 mctl cleared", A_MCTL, 8'h00);
    rd_chk("R8 diag kept",    A_DIAG, 8'h42);
    rd_chk("R8 sysc kept",    A_SYSC, 8'h02);
  endtask

  task automatic t_por;
    @(negedge clk);
    por_n = 1'b0;
    @(negedge clk);
    por_n = 1'b1;
    rd_chk("R9 diag cleared", A_DIAG, 8'h00);
    rd_chk("R9 sysc cleared", A_SYSC, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; por_n = 1'b0;
    bus_wr = 1'b0; bus_rd = 1'b0; pwr_fail = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    t_reset_state();
    t_plain_regs();
    t_undecoded();
    t_power_fail();
    t_shutdown();
    t_sysctl();
    t_soft_reset();
    t_por();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule